// File: doc/BRIEF.md
# Bus-Attached I/O Register Target with Wait-State Insertion

This block is a synchronous model of an 8-bit peripheral sitting on a legacy PC expansion bus. It holds a small bank of byte registers mapped at a configurable base in the 64K I/O space. All bus control inputs (address latch enable, DMA address enable, read strobe and write strobe) are brought into the local clock domain through two-flop synchronizers. The block then watches for edges and decodes a board select from an address latched when the latch enable falls.

On a selected read the block enables its data drivers and presents the addressed register. On a selected write it captures the data lines and commits them to the register when the write strobe rises, giving the user logic a one-cycle strobe with the register index. A programmable count makes the block drop its ready line for that many clocks at the start of each selected command, which stretches the bus cycle. A count of zero leaves the ready line high.

The control is a four-state machine. IDLE waits for a command. STALL holds ready low while the wait counter runs. READ drives data. WRITE samples data until commit. The transitions are:

- IDLE to STALL on a selected command with a nonzero count.
- IDLE to READ or IDLE to WRITE on a selected command with a zero count.
- STALL to READ or STALL to WRITE when the counter expires.
- STALL to IDLE if the master withdraws the strobe early. This is an abort, and no commit takes place.
- READ to IDLE when the read strobe rises.
- WRITE to IDLE when the write strobe rises. This is the commit.

Top module: `isa_io_target`

## Requirements
- R1: The board is selected only when the low 16 latched address bits fall in [BASE, BASE+NREG). Bits 19:16 have no effect. The register index is the low log2(NREG) address bits.
- R2: The address is captured on the falling edge of the synchronized latch enable and held unchanged until the next falling edge. Address changes after capture do not affect the command.
- R3: If bus_aen is high when a command starts, the command is ignored: io_ready stays high, data_oe stays low and no register is written.
- R4: During a selected read, data_oe is high and data_out equals the addressed register. data_oe is low again by the third rising clock edge after bus_rd_n rises.
- R5: A selected write stores data_in (held stable through the strobe) into the addressed register. The store happens after bus_wr_n rises, together with a single-cycle wr_pulse and wr_index equal to the register index.
- R6: With wait_cycles = N > 0, io_ready is low for exactly N consecutive clocks on each selected command, starting on the third rising edge after the strobe falls.
- R7: With wait_cycles = 0, io_ready never goes low.
- R8: After reset all registers are zero, io_ready is high, data_oe is low and wr_pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 20 | System address lines |
| bus_aen | input | 1 | DMA address enable, high during DMA |
| bus_ale | input | 1 | Address latch enable, address captured on fall |
| bus_rd_n | input | 1 | I/O read strobe, active low |
| bus_wr_n | input | 1 | I/O write strobe, active low |
| data_in | input | 8 | Data lines as seen by the block |
| data_out | output | 8 | Read data for the data lines |
| data_oe | output | 1 | Tristate enable for data_out |
| io_ready | output | 1 | Channel ready, low inserts wait states |
| wait_cycles | input | WAIT_W | Wait states inserted per selected command |
| reg_bank | output | NREG*8 | All registers, register i at bits [8i+7:8i] |
| wr_pulse | output | 1 | One-cycle strobe on register commit |
| wr_index | output | IDX_W | Index of the committed register |

## Verification
The assertions assume that the bus master behaves like a proper bus owner. It asserts at most one strobe at a time, keeps bus_aen constant through a command, and does not raise the latch enable during a command. The write-data capture also relies on data_in staying stable until two clocks after the write strobe rises, and the latch relies on the address staying stable three clocks after the latch enable falls. The stimulus drives every input on the falling clock edge and follows this discipline in every cycle. It scrambles the address only after the capture window, to show that the latched copy is used. It holds write data four clocks past the strobe and waits while io_ready is low before releasing a strobe.

// File: rtl/isa_io_pkg.sv
package isa_io_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STALL = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } isa_state_t;

    localparam int IO_SPACE_BITS = 16;
endpackage

// File: rtl/isa_io_sync.sv
module isa_io_sync #(
    parameter int W = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[b] <= RST_VAL[b];
                stage2[b] <= RST_VAL[b];
            end else begin
                stage1[b] <= d[b];
                stage2[b] <= stage1[b];
            end
        end
    end

    assign q = stage2;
endmodule

// File: rtl/isa_io_addr_latch.sv
module isa_io_addr_latch #(
    parameter int ADDR_W = 20,
    parameter logic [15:0] BASE = 16'h0300,
    parameter int NREG = 4,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int IOW = isa_io_pkg::IO_SPACE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_s,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    logic           ale_prev;
    logic           ale_fall;
    logic [IOW-1:0] addr_q;

    assign ale_fall = ale_prev && !ale_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ale_prev <= 1'b0;
            addr_q   <= '0;
        end else begin
            ale_prev <= ale_s;
            if (ale_fall) addr_q <= addr[IOW-1:0];
        end
    end

    assign hit = (addr_q[IOW-1:IDX_W] == BASE[IOW-1:IDX_W]);
    assign idx = addr_q[IDX_W-1:0];

    assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ale_fall |=> $stable(addr_q));
endmodule

// File: rtl/isa_io_regbank.sv
module isa_io_regbank #(
    parameter int NREG = 4,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [7:0]        wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [7:0]        rdata,
    output logic [NREG*8-1:0] bank_flat
);
    logic [7:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  regs[i] <= 8'h00;
            else if (we && (widx == IDX_W'(i)))          regs[i] <= wdata;
        end
        assign bank_flat[i*8 +: 8] = regs[i];
    end

    assign rdata = regs[ridx];
endmodule

// File: rtl/isa_io_target.sv
module isa_io_target #(
    parameter int ADDR_W = 20,
    parameter logic [15:0] BASE = 16'h0300,
    parameter int NREG = 4,
    parameter int WAIT_W = 3,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_aen,
    input  logic              bus_ale,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic [7:0]        data_in,
    output logic [7:0]        data_out,
    output logic              data_oe,
    output logic              io_ready,
    input  logic [WAIT_W-1:0] wait_cycles,
    output logic [NREG*8-1:0] reg_bank,
    output logic              wr_pulse,
    output logic [IDX_W-1:0]  wr_index
);
    import isa_io_pkg::*;

    isa_state_t state, state_nx;

    logic [3:0] sync_q;
    logic aen_s, ale_s, rd_s, wr_s;
    logic rd_prev, wr_prev;
    logic rd_fall, wr_fall;
    logic hit;
    logic [IDX_W-1:0] idx;
    logic is_wr_q;
    logic [WAIT_W-1:0] cnt_q;
    logic [7:0] wdata_q;
    logic commit;
    logic start;
    logic start_wr;
    logic cmd_gone;

    isa_io_sync #(.W(4), .RST_VAL(4'b0011)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({bus_aen, bus_ale, bus_rd_n, bus_wr_n}),
        .q    (sync_q)
    );
    assign {aen_s, ale_s, rd_s, wr_s} = sync_q;

    isa_io_addr_latch #(.ADDR_W(ADDR_W), .BASE(BASE), .NREG(NREG)) u_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .ale_s(ale_s),
        .addr (bus_addr),
        .hit  (hit),
        .idx  (idx)
    );

    isa_io_regbank #(.NREG(NREG)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (commit),
        .widx     (idx),
        .wdata    (wdata_q),
        .ridx     (idx),
        .rdata    (data_out),
        .bank_flat(reg_bank)
    );

    assign rd_fall  = rd_prev && !rd_s;
    assign wr_fall  = wr_prev && !wr_s;
    assign start    = (rd_fall || wr_fall) && hit && !aen_s;
    assign start_wr = !rd_fall;
    assign cmd_gone = is_wr_q ? wr_s : rd_s;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (wait_cycles != '0) state_nx = ST_STALL;
                    else                   state_nx = start_wr ? ST_WRITE : ST_READ;
                end
            end
            ST_STALL: begin
                if (cmd_gone)                     state_nx = ST_IDLE;
                else if (cnt_q == WAIT_W'(1))     state_nx = is_wr_q ? ST_WRITE : ST_READ;
            end
            ST_READ:  if (rd_s) state_nx = ST_IDLE;
            ST_WRITE: if (wr_s) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            rd_prev  <= 1'b1;
            wr_prev  <= 1'b1;
            is_wr_q  <= 1'b0;
            cnt_q    <= '0;
            wdata_q  <= 8'h00;
            wr_pulse <= 1'b0;
            wr_index <= '0;
        end else begin
            state    <= state_nx;
            rd_prev  <= rd_s;
            wr_prev  <= wr_s;
            wr_pulse <= commit;
            if (commit) wr_index <= idx;
            if (state == ST_IDLE) begin
                cnt_q <= wait_cycles;
                if (start) is_wr_q <= start_wr;
            end else if (state == ST_STALL) begin
                cnt_q <= cnt_q - WAIT_W'(1);
            end
            if (is_wr_q && !wr_s && (state == ST_STALL || state == ST_WRITE))
                wdata_q <= data_in;
        end
    end

    // outputs
    always_comb begin
        io_ready = (state != ST_STALL);
        data_oe  = (state == ST_READ) || (state == ST_STALL && !is_wr_q);
        commit   = (state == ST_WRITE) && wr_s;
    end

    assert_dma_never_selects_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && aen_s) |=> (state == ST_IDLE));

    assert_zero_wait_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wait_cycles == '0) |=> io_ready);

    assert_stall_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STALL && cnt_q == WAIT_W'(1)) |=> io_ready);

    assert_oe_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && rd_s) |=> !data_oe);

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);
endmodule

// File: tb/isa_io_target_test.sv
module isa_io_target_test;
    localparam int NREG = 4;
    localparam int WAIT_W = 3;
    localparam logic [15:0] BASE = 16'h0300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        bus_aen = 1'b0;
    logic        bus_ale = 1'b0;
    logic        bus_rd_n = 1'b1;
    logic        bus_wr_n = 1'b1;
    logic [7:0]  data_in = '0;
    logic [7:0]  data_out;
    logic        data_oe;
    logic        io_ready;
    logic [WAIT_W-1:0] wait_cycles = '0;
    logic [NREG*8-1:0] reg_bank;
    logic        wr_pulse;
    logic [1:0]  wr_index;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [7:0] model [NREG];

    isa_io_target #(.BASE(BASE), .NREG(NREG), .WAIT_W(WAIT_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_aen(bus_aen),
        .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .io_ready(io_ready), .wait_cycles(wait_cycles), .reg_bank(reg_bank),
        .wr_pulse(wr_pulse), .wr_index(wr_index)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_bank(input string req);
        for (int i = 0; i < NREG; i++) chk(req, reg_bank[i*8 +: 8], model[i]);
    endtask

    // one bus command; results observed at the ports
    task automatic bus_cmd(input bit wr, input logic [19:0] a, input logic [19:0] a_late,
                           input bit dma, input logic [7:0] wd,
                           output logic [7:0] rd, output int stalls, output int pulses,
                           output int pidx, output int oe_seen, output int oe_late);
        int n;
        rd = 8'hxx; stalls = 0; pulses = 0; pidx = -1; oe_seen = 0; oe_late = 0;
        @(negedge clk);
        bus_addr = a; bus_aen = dma; bus_ale = 1'b1;
        repeat (2) @(negedge clk);
        bus_ale = 1'b0;
        repeat (3) @(negedge clk);
        bus_addr = a_late;
        @(negedge clk);
        if (wr) begin data_in = wd; bus_wr_n = 1'b0; end
        else bus_rd_n = 1'b0;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (!io_ready) stalls++;
            if (data_oe) begin oe_seen = 1; rd = data_out; end
            if (wr_pulse) begin pulses++; pidx = wr_index; end
            if ((n >= 6 && io_ready) || n > 60) break;
        end
        bus_rd_n = 1'b1; bus_wr_n = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (k == 3) oe_late = data_oe;
            if (!io_ready) stalls++;
            if (wr_pulse) begin pulses++; pidx = wr_index; end
        end
        bus_aen = 1'b0;
        data_in = 8'h00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int stalls, pulses, pidx, oe_seen, oe_late;
        logic [7:0] v;
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;

        repeat (3) @(negedge clk);
        chk("R8 ready at reset", io_ready, 1);
        chk("R8 oe at reset", data_oe, 0);
        chk("R8 pulse at reset", wr_pulse, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_bank("R8 bank zero");

        // sweep all wait counts and all registers: write then read back
        for (int w = 0; w < (1 << WAIT_W); w++) begin
            wait_cycles = WAIT_W'(w);
            for (int i = 0; i < NREG; i++) begin
                v = 8'((w * 37 + i * 11 + 5) & 8'hFF);
                bus_cmd(1'b1, {4'h0, BASE + 16'(i)}, {4'h0, BASE + 16'(i)}, 1'b0, v,
                        rd, stalls, pulses, pidx, oe_seen, oe_late);
                model[i] = v;
                chk(w == 0 ? "R7 write no stall" : "R6 write stall length", stalls, w);
                chk("R5 one pulse", pulses, 1);
                chk("R5 pulse index", pidx, i);
                chk("R5 write oe", oe_seen, 0);
                chk_bank("R5 bank after write");

                bus_cmd(1'b0, {4'h0, BASE + 16'(i)}, {4'h0, BASE + 16'(i)}, 1'b0, 8'h00,
                        rd, stalls, pulses, pidx, oe_seen, oe_late);
                chk(w == 0 ? "R7 read no stall" : "R6 read stall length", stalls, w);
                chk("R4 oe asserted", oe_seen, 1);
                chk("R4 read data", rd, v);
                chk("R4 oe released", oe_late, 0);
                chk("R4 no pulse on read", pulses, 0);
            end
        end

        wait_cycles = 3'd2;
        // R1: upper address bits ignored
        bus_cmd(1'b1, {4'hA, BASE + 16'd2}, {4'hA, BASE + 16'd2}, 1'b0, 8'h5A,
                rd, stalls, pulses, pidx, oe_seen, oe_late);
        model[2] = 8'h5A;
        chk("R1 upper bits ignored pulse", pulses, 1);
        chk_bank("R1 upper bits ignored bank");

        // R1: addresses just outside the window
        for (int k = 0; k < 4; k++) begin
            logic [15:0] aa;
            aa = (k == 0) ? BASE - 16'd1 : (k == 1) ? BASE + 16'(NREG)
               : (k == 2) ? BASE ^ 16'h1000 : BASE ^ 16'h0004;
            bus_cmd(1'b1, {4'h0, aa}, {4'h0, aa}, 1'b0, 8'hEE,
                    rd, stalls, pulses, pidx, oe_seen, oe_late);
            chk("R1 miss write stall", stalls, 0);
            chk("R1 miss write pulse", pulses, 0);
            chk_bank("R1 miss bank");
            bus_cmd(1'b0, {4'h0, aa}, {4'h0, aa}, 1'b0, 8'h00,
                    rd, stalls, pulses, pidx, oe_seen, oe_late);
            chk("R1 miss read oe", oe_seen, 0);
        end

        // R3: DMA cycle at a matching address
        bus_cmd(1'b1, {4'h0, BASE + 16'd1}, {4'h0, BASE + 16'd1}, 1'b1, 8'hC3,
                rd, stalls, pulses, pidx, oe_seen, oe_late);
        chk("R3 dma write stall", stalls, 0);
        chk("R3 dma write pulse", pulses, 0);
        chk_bank("R3 dma bank");
        bus_cmd(1'b0, {4'h0, BASE + 16'd1}, {4'h0, BASE + 16'd1}, 1'b1, 8'h00,
                rd, stalls, pulses, pidx, oe_seen, oe_late);
        chk("R3 dma read oe", oe_seen, 0);
        chk("R3 dma read stall", stalls, 0);

        // R2: latched address wins over later bus address
        bus_cmd(1'b1, {4'h0, BASE + 16'd3}, 20'h0ABCD, 1'b0, 8'h77,
                rd, stalls, pulses, pidx, oe_seen, oe_late);
        model[3] = 8'h77;
        chk("R2 latched hit pulse", pulses, 1);
        chk("R2 latched hit index", pidx, 3);
        chk_bank("R2 latched bank");
        bus_cmd(1'b1, 20'h0ABCD, {4'h0, BASE}, 1'b0, 8'h99,
                rd, stalls, pulses, pidx, oe_seen, oe_late);
        chk("R2 latched miss pulse", pulses, 0);
        chk_bank("R2 latched miss bank");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule